// File: doc/BRIEF.md
# Serial Line Loss-of-Signal Monitor

This block watches a recovered serial line, one bit period per clock-enable pulse, and keeps a loss-of-signal (LOS) status for the receive path. A bit period counts as a one when either the positive or the negative rail input is high, and as a zero otherwise. LOS is declared when a long run of consecutive zero bits arrives, or at once whenever the external line-receiver LOS input is high. A configuration input can switch off the zero-run criterion, so that only the external input declares LOS.

Clearing is decided differently from declaring. Once LOS is active, the received bits are grouped into back-to-back, non-overlapping windows of fixed length. The first window starts right after declaration. At the end of each window, LOS clears if the window held enough ones and the external input is low. Otherwise a new window begins. On every change of status the block emits a one-cycle interrupt pulse. On declaration it also pulses an out-of-frame request toward the framer, and it holds a far-end failure request toward the transmitter for as long as LOS lasts.

Top module: `lineLossMonitor`

## Requirements
- R1: With the disable input low, LOS is asserted on the clock edge that follows the enabled bit period completing RUN_LEN (default 180) consecutive zero bits. Only periods with bitEn high count, and a bit is one when railPos or railNeg is high.
- R2: While LOS is inactive, extLos high asserts LOS on the next clock edge, whether or not bitEn is high.
- R3: While LOS is active, enabled bits form consecutive non-overlapping windows of WIN_LEN (default 180) bits, the first starting after declaration. LOS clears on the edge after a window's last bit if that window held at least ONES_MIN (default 60) ones and extLos is low.
- R4: A window with fewer than ONES_MIN ones leaves LOS asserted, and counting restarts with a fresh window.
- R5: losChangeIrq is high for exactly one cycle, in the first cycle in which losOut shows a new value, on both declaration and clearing.
- R6: With intLosDisable high, a zero run of any length has no effect on LOS, and only extLos can declare it.
- R7: While extLos is high, LOS stays asserted whatever the ones density of a completed window.
- R8: losOut is high while LOS is active. statusByte carries LOS in bit 6, and its other bits are zero.
- R9: oofReq pulses for one cycle together with the declaration edge. farEndFailReq is high exactly while LOS is active.
- R10: After reset, LOS and all outputs are low, and the zero-run and window counts start from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitEn | input | 1 | Marks a cycle that carries one received bit period |
| railPos | input | 1 | Positive rail pulse for the current bit period |
| railNeg | input | 1 | Negative rail pulse for the current bit period |
| extLos | input | 1 | Loss indication from the external line receiver |
| intLosDisable | input | 1 | 1 turns off the zero-run declaration criterion |
| losOut | output | 1 | LOS status |
| statusByte | output | 8 | Status byte, LOS in bit 6, other bits zero |
| losChangeIrq | output | 1 | One-cycle pulse on each LOS change |
| oofReq | output | 1 | One-cycle out-of-frame request on declaration |
| farEndFailReq | output | 1 | Far-end receive failure request, high during LOS |

## Verification
All results come from a single register stage. The LOS status, the status byte, the interrupt pulse, the out-of-frame pulse and the far-end request all change on the clock edge right after the bit period (or the extLos cycle) that causes them, so the latency is one edge. The bench drives inputs on the falling edge and steps a behavioural model on the rising edge. It compares every output on the next falling edge. Directed checks sample one time unit after the rising edge that consumes the decisive bit, which puts them exactly at the boundary bits: the 179th and 180th zero, and the last bit of a window with 59 or 60 ones.

// File: rtl/lossPkg.sv
package lossPkg;

  // Events reported by the datapath to the control for the current cycle
  typedef struct packed {
    logic runDone;   // this enabled zero completes the declaration run
    logic winEnd;    // this enabled bit is the last of a clearing window
    logic winPass;   // ones in the window, this bit included, reach the minimum
  } lossEvt_t;

  // Mode handed from the control to the datapath
  typedef struct packed {
    logic losActive;
  } lossMode_t;

endpackage

// File: rtl/lossDatapath.sv
module lossDatapath
  import lossPkg::*;
#(
  parameter int RUN_LEN  = 180,
  parameter int WIN_LEN  = 180,
  parameter int ONES_MIN = 60
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitEn,
  input  logic      railPos,
  input  logic      railNeg,
  input  lossMode_t mode,
  output lossEvt_t  evt
);

  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam int WIN_W = $clog2(WIN_LEN + 1);

  logic [RUN_W-1:0] zeroRun;
  logic [WIN_W-1:0] winCnt;
  logic [WIN_W-1:0] onesCnt;
  logic             bitOne;
  logic             runLast;
  logic             winLast;
  logic [WIN_W:0]   onesSum;

  assign bitOne  = railPos | railNeg;
  assign runLast = (zeroRun == RUN_W'(RUN_LEN - 1));
  assign winLast = (winCnt == WIN_W'(WIN_LEN - 1));
  assign onesSum = {1'b0, onesCnt} + (WIN_W + 1)'(bitOne);

  always_comb begin
    evt.runDone = bitEn & ~bitOne & runLast & ~mode.losActive;
    evt.winEnd  = bitEn & winLast & mode.losActive;
    evt.winPass = (onesSum >= (WIN_W + 1)'(ONES_MIN));
  end

  // Zero-run counter, saturating one short of the run length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zeroRun <= '0;
    end else if (mode.losActive) begin
      zeroRun <= '0;
    end else if (bitEn) begin
      if (bitOne)        zeroRun <= '0;
      else if (!runLast) zeroRun <= zeroRun + 1'b1;
    end
  end

  // Clearing window: bit count and ones count, active only during LOS
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt  <= '0;
      onesCnt <= '0;
    end else if (!mode.losActive) begin
      winCnt  <= '0;
      onesCnt <= '0;
    end else if (bitEn) begin
      if (winLast) begin
        winCnt  <= '0;
        onesCnt <= '0;
      end else begin
        winCnt  <= winCnt + 1'b1;
        onesCnt <= onesSum[WIN_W-1:0];
      end
    end
  end

endmodule

// File: rtl/lossControl.sv
module lossControl
  import lossPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      extLos,
  input  logic      intLosDisable,
  input  lossEvt_t  evt,
  output lossMode_t mode,
  output logic      losState,
  output logic      changePulse,
  output logic      declarePulse
);

  logic losNext;

  always_comb begin
    if (losState)
      losNext = ~(evt.winEnd & evt.winPass & ~extLos);
    else
      losNext = extLos | (evt.runDone & ~intLosDisable);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      losState     <= 1'b0;
      changePulse  <= 1'b0;
      declarePulse <= 1'b0;
    end else begin
      losState     <= losNext;
      changePulse  <= losNext ^ losState;
      declarePulse <= losNext & ~losState;
    end
  end

  assign mode.losActive = losState;

endmodule

// File: rtl/lineLossMonitor.sv
module lineLossMonitor
  import lossPkg::*;
#(
  parameter int RUN_LEN  = 180,
  parameter int WIN_LEN  = 180,
  parameter int ONES_MIN = 60
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       railPos,
  input  logic       railNeg,
  input  logic       extLos,
  input  logic       intLosDisable,
  output logic       losOut,
  output logic [7:0] statusByte,
  output logic       losChangeIrq,
  output logic       oofReq,
  output logic       farEndFailReq
);

  localparam int STATUS_LOS_BIT = 6;

  lossEvt_t  evt;
  lossMode_t mode;
  logic      losState;

  lossDatapath #(
    .RUN_LEN (RUN_LEN),
    .WIN_LEN (WIN_LEN),
    .ONES_MIN(ONES_MIN)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .bitEn  (bitEn),
    .railPos(railPos),
    .railNeg(railNeg),
    .mode   (mode),
    .evt    (evt)
  );

  lossControl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .extLos       (extLos),
    .intLosDisable(intLosDisable),
    .evt          (evt),
    .mode         (mode),
    .losState     (losState),
    .changePulse  (losChangeIrq),
    .declarePulse (oofReq)
  );

  assign losOut        = losState;
  assign farEndFailReq = losState;

  always_comb begin
    statusByte                 = '0;
    statusByte[STATUS_LOS_BIT] = losState;
  end

endmodule

// File: rtl/lineLossMonitorChk.sv
module lineLossMonitorChk (
  input logic       clk,
  input logic       rstN,
  input logic       bitEn,
  input logic       railPos,
  input logic       railNeg,
  input logic       extLos,
  input logic       intLosDisable,
  input logic       losOut,
  input logic [7:0] statusByte,
  input logic       losChangeIrq,
  input logic       oofReq,
  input logic       farEndFailReq
);

  // R1: an internal declaration needs an enabled zero bit with the criterion on
  p_zero_declare_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(losOut) && !$past(extLos)) |->
      $past(bitEn && !railPos && !railNeg && !intLosDisable));

  // R2: the external input declares on the next edge
  p_ext_declare_r2: assert property (@(posedge clk) disable iff (!rstN)
    extLos |=> losOut);

  // R3: clearing happens only at an enabled bit
  p_clear_on_bit_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(losOut) |-> $past(bitEn));

  // R5: a pulse exactly on each change
  p_irq_on_change_r5: assert property (@(posedge clk) disable iff (!rstN)
    (losOut != $past(losOut)) |-> losChangeIrq);
  p_irq_only_change_r5: assert property (@(posedge clk) disable iff (!rstN)
    losChangeIrq |-> (losOut != $past(losOut)));

  // R6: with the criterion off and no external loss, no declaration
  p_disable_blocks_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!losOut && !extLos && intLosDisable) |=> !losOut);

  // R7: the external input holds LOS
  p_ext_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (losOut && extLos) |=> losOut);

  // R8: status byte mirrors the status in bit 6 only
  p_status_byte_r8: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[6] == losOut) && ($countones(statusByte) <= 1));

  // R9: out-of-frame pulse on the rise, far-end request follows the status
  p_oof_on_rise_r9: assert property (@(posedge clk) disable iff (!rstN)
    oofReq |-> (losOut && !$past(losOut)));
  p_far_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    farEndFailReq == losOut);

endmodule

bind lineLossMonitor lineLossMonitorChk chk (
  .clk          (clk),
  .rstN         (rstN),
  .bitEn        (bitEn),
  .railPos      (railPos),
  .railNeg      (railNeg),
  .extLos       (extLos),
  .intLosDisable(intLosDisable),
  .losOut       (losOut),
  .statusByte   (statusByte),
  .losChangeIrq (losChangeIrq),
  .oofReq       (oofReq),
  .farEndFailReq(farEndFailReq)
);

// File: tb/lineLossMonitor_test.sv
module lineLossMonitor_test;

  localparam int CLK_PERIOD = 10;
  localparam int RUN = 180;
  localparam int WIN = 180;
  localparam int MINONES = 60;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b0;
  logic       railPos = 1'b0;
  logic       railNeg = 1'b0;
  logic       extLos = 1'b0;
  logic       intLosDisable = 1'b0;
  logic       losOut;
  logic [7:0] statusByte;
  logic       losChangeIrq;
  logic       oofReq;
  logic       farEndFailReq;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;
  bit  altRail = 1'b0;

  // behavioural reference state
  int  mZeros = 0;
  int  mWinBits = 0;
  int  mWinOnes = 0;
  bit  mLos = 1'b0;
  bit  mIrq = 1'b0;
  bit  mOof = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lineLossMonitor uut (
    .clk          (clk),
    .rstN         (rstN),
    .bitEn        (bitEn),
    .railPos      (railPos),
    .railNeg      (railNeg),
    .extLos       (extLos),
    .intLosDisable(intLosDisable),
    .losOut       (losOut),
    .statusByte   (statusByte),
    .losChangeIrq (losChangeIrq),
    .oofReq       (oofReq),
    .farEndFailReq(farEndFailReq)
  );

  // Reference model: one step per rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mZeros = 0; mWinBits = 0; mWinOnes = 0;
      mLos = 1'b0; mIrq = 1'b0; mOof = 1'b0;
    end else begin
      bit one;
      bit nextLos;
      one = railPos || railNeg;
      if (mLos) begin
        nextLos = 1'b1;
        if (bitEn && mWinBits == WIN - 1 && (mWinOnes + one) >= MINONES && !extLos)
          nextLos = 1'b0;
      end else begin
        nextLos = extLos || (bitEn && !one && mZeros + 1 >= RUN && !intLosDisable);
      end
      if (mLos) mZeros = 0;
      else if (bitEn) mZeros = one ? 0 : mZeros + 1;
      if (!mLos) begin
        mWinBits = 0; mWinOnes = 0;
      end else if (bitEn) begin
        if (mWinBits == WIN - 1) begin
          mWinBits = 0; mWinOnes = 0;
        end else begin
          mWinBits = mWinBits + 1; mWinOnes = mWinOnes + one;
        end
      end
      mIrq = (nextLos != mLos);
      mOof = nextLos && !mLos;
      mLos = nextLos;
    end
  end

  // Every-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      total += 5;
      if (losOut !== mLos) begin
        bad++; $display("FAIL R8 losOut=%0b expected %0b at %0t", losOut, mLos, $time);
      end
      if (statusByte !== {1'b0, mLos, 6'b0}) begin
        bad++; $display("FAIL R8 statusByte=%h expected %h", statusByte, {1'b0, mLos, 6'b0});
      end
      if (losChangeIrq !== mIrq) begin
        bad++; $display("FAIL R5 losChangeIrq=%0b expected %0b at %0t", losChangeIrq, mIrq, $time);
      end
      if (oofReq !== mOof) begin
        bad++; $display("FAIL R9 oofReq=%0b expected %0b at %0t", oofReq, mOof, $time);
      end
      if (farEndFailReq !== mLos) begin
        bad++; $display("FAIL R9 farEndFailReq=%0b expected %0b", farEndFailReq, mLos);
      end
    end
  end

  task automatic drive(input bit b, input bit en);
    @(negedge clk);
    bitEn   = en;
    railPos = b & en & ~altRail;
    railNeg = b & en & altRail;
    if (b && en) altRail = ~altRail;
  endtask

  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b1);
  endtask

  // one window of WIN bits holding exactly k ones (k <= WIN/3)
  task automatic windowOnes(input int k);
    for (int i = 0; i < WIN; i++) drive((i % 3 == 0) && (i / 3 < k), 1'b1);
  endtask

  // sample one time unit after the edge that consumes the last driven bit
  task automatic checkOut(input string tag, input bit expLos, input bit expIrq, input bit expOof);
    @(posedge clk);
    #1;
    total++;
    if (losOut !== expLos || losChangeIrq !== expIrq || oofReq !== expOof ||
        statusByte !== {1'b0, expLos, 6'b0} || farEndFailReq !== expLos) begin
      bad++;
      $display("FAIL %s los/irq/oof/status=%0b/%0b/%0b/%h expected %0b/%0b/%0b/%h",
               tag, losOut, losChangeIrq, oofReq, statusByte,
               expLos, expIrq, expOof, {1'b0, expLos, 6'b0});
    end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10: reset state
    checkOut("R10 reset", 1'b0, 1'b0, 1'b0);

    // R1 boundary: 179 zeros then a one do not declare
    zeros(RUN - 1);
    checkOut("R1 179 zeros", 1'b0, 1'b0, 1'b0);
    drive(1'b1, 1'b1);
    zeros(RUN - 1);
    checkOut("R1 run restarted by a one", 1'b0, 1'b0, 1'b0);

    // R1, R5, R8, R9: the 180th zero declares
    drive(1'b0, 1'b1);
    checkOut("R1 R9 declare on 180th zero", 1'b1, 1'b1, 1'b1);
    drive(1'b0, 1'b0);
    checkOut("R5 irq lasts one cycle", 1'b1, 1'b0, 1'b0);

    // R4: 59 ones leave LOS set; R3: 60 ones in the next window clear it
    windowOnes(MINONES - 1);
    checkOut("R4 window with 59 ones", 1'b1, 1'b0, 1'b0);
    windowOnes(MINONES);
    checkOut("R3 R5 clear on 60 ones", 1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b0);
    checkOut("R5 clear pulse ends", 1'b0, 1'b0, 1'b0);

    // R2: external input declares without bit enable
    @(negedge clk); extLos = 1'b1; bitEn = 1'b0; railPos = 1'b0; railNeg = 1'b0;
    checkOut("R2 external declare", 1'b1, 1'b1, 1'b1);
    // R7: all-ones window with external loss held does not clear
    for (int i = 0; i < WIN; i++) drive(1'b1, 1'b1);
    checkOut("R7 held by external input", 1'b1, 1'b0, 1'b0);
    @(negedge clk); extLos = 1'b0; bitEn = 1'b0; railPos = 1'b0; railNeg = 1'b0;
    windowOnes(MINONES);
    checkOut("R3 clear after external drops", 1'b0, 1'b1, 1'b0);

    // R6: criterion disabled, long zero run ignored; external still declares
    intLosDisable = 1'b1;
    zeros(RUN + 120);
    checkOut("R6 zero run ignored", 1'b0, 1'b0, 1'b0);
    @(negedge clk); extLos = 1'b1; bitEn = 1'b0; railPos = 1'b0; railNeg = 1'b0;
    checkOut("R6 R2 external declares while disabled", 1'b1, 1'b1, 1'b1);
    @(negedge clk); extLos = 1'b0;
    windowOnes(MINONES);
    checkOut("R3 clear while disabled", 1'b0, 1'b1, 1'b0);
    intLosDisable = 1'b0;

    // R1 with gapped enables: idle cycles do not break or advance the run
    for (int i = 0; i < RUN - 1; i++) begin
      drive(1'b0, 1'b1);
      drive(1'b1, 1'b0);
    end
    checkOut("R1 gapped 179 zeros", 1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b1);
    checkOut("R1 gapped declare", 1'b1, 1'b1, 1'b1);
    // R3 with idle gaps inside the window
    for (int i = 0; i < WIN; i++) begin
      drive(i % 3 == 0, 1'b1);
      drive(1'b0, 1'b0);
    end
    checkOut("R3 gapped window clears", 1'b0, 1'b0, 1'b0);

    // R10: reset in the middle of a run clears it
    zeros(RUN - 10);
    @(negedge clk); rstN = 1'b0; bitEn = 1'b0;
    @(negedge clk); rstN = 1'b1;
    zeros(20);
    checkOut("R10 reset restarts run", 1'b0, 1'b0, 1'b0);

    repeat (3) @(negedge clk);
    summary();
  end

endmodule